// File: doc/BRIEF.md
# Atomic Lock and Counting Semaphore Unit

This block gives several requesters a shared set of hardware locks and one counting semaphore. Each requester has its own request lane. A lane carries a valid bit, a two-bit operation code and a lock index. The block checks the current state, updates it and records the result, all in a single clock edge. No other requester can act between the test and the update of a lock. The result comes back on a registered response lane one cycle after the request.

Each lock bit is 0 when free and 1 when held. The block stores the requester ID that holds each lock, so it can catch misuse: a release by a requester that does not hold the lock, or a second take by the requester that already holds it. The semaphore counts the slots in use and refuses a take once the count reaches a programmable limit. A give on an empty semaphore is flagged as underflow.

When several lanes request in the same cycle, the block applies them in ascending lane order. Each lane sees the state left by the lanes below it.

Top module: `lock_sem_unit`

## Requirements
- R1: After reset, every lock is free, the semaphore count is 0, the limit is 10 and no response is valid.
- R2: A lock take (op 2'b00) on a free lock is granted. Its response shows prior value 0, and the lock bit reads 1 from the same edge. Every response is valid exactly one cycle after its request, and only then.
- R3: A lock take on a lock held by another lane is refused. It returns prior value 1, raises no error and leaves the lock state unchanged.
- R4: A lock take by the lane that already holds the lock is refused and raises the error flag. Grant and error are never both set.
- R5: A lock release (op 2'b01) by the holder clears the lock and is granted. A release by any other lane, or on a free lock, is ignored: the lock state is unchanged and the error flag is raised.
- R6: Requests in the same cycle are applied in ascending lane order. A lane sees the effects of the lower lanes, so at most one lane wins a free lock in a cycle, and a release followed by a higher-lane take in the same cycle hands the lock over.
- R7: A semaphore take (op 2'b10) is granted and increments the count while count < limit. Otherwise it is refused, with no error and no change to the count.
- R8: A semaphore give (op 2'b11) decrements a nonzero count and is granted. At count 0 the count stays 0 and the error flag is raised.
- R9: A limit write is visible on the limit output from the next edge. Semaphore requests in the write cycle still use the old limit.
- R10: Semaphore operations ignore the lock index field and never change any lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NUM_REQ | Request valid, one bit per lane |
| req_op_i | input | 2*NUM_REQ | Operation code per lane, lane n at bits [2n+1:2n] |
| req_idx_i | input | IDX_W*NUM_REQ | Lock index per lane |
| cfg_we_i | input | 1 | Semaphore limit write enable |
| cfg_limit_i | input | CNT_W | New semaphore limit |
| rsp_valid_o | output | NUM_REQ | Response valid per lane |
| rsp_grant_o | output | NUM_REQ | Operation granted |
| rsp_prior_o | output | NUM_REQ | Lock value seen by a lock take |
| rsp_err_o | output | NUM_REQ | Misuse or underflow flag |
| mtx_held_o | output | NUM_MTX | Current lock bits |
| sem_count_o | output | CNT_W | Current semaphore count |
| sem_limit_o | output | CNT_W | Current semaphore limit |

## Verification
Lock bits, the semaphore count and the response of a request all change at the first rising edge after the request is driven. The limit output changes at the first edge after a write. The bench drives each request on a falling edge and samples one full period later, on the next falling edge, after that single register stage. It clears the request before the next one, so a response that is still valid one cycle late is caught. Same-cycle scenarios load several lanes on one falling edge and compare every lane's response against the ascending-order outcome.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    OP_MTX_TAKE = 2'b00,
    OP_MTX_GIVE = 2'b01,
    OP_SEM_TAKE = 2'b10,
    OP_SEM_GIVE = 2'b11
  } lsu_op_e;
endpackage

// File: rtl/lsu_stage.sv
module lsu_stage
  import lsu_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int NUM_MTX = 8,
  parameter int CNT_W   = 5,
  parameter int REQ_ID  = 0,
  localparam int ID_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int IDX_W = (NUM_MTX > 1) ? $clog2(NUM_MTX) : 1
) (
  input  logic                    valid_i,
  input  logic [1:0]              op_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [NUM_MTX-1:0]      held_i,
  input  logic [NUM_MTX*ID_W-1:0] owner_i,
  input  logic [CNT_W-1:0]        count_i,
  input  logic [CNT_W-1:0]        limit_i,
  output logic [NUM_MTX-1:0]      held_o,
  output logic [NUM_MTX*ID_W-1:0] owner_o,
  output logic [CNT_W-1:0]        count_o,
  output logic                    grant_o,
  output logic                    prior_o,
  output logic                    err_o
);
  localparam logic [ID_W-1:0] MY_ID = ID_W'(REQ_ID);

  lsu_op_e         op;
  logic [ID_W-1:0] cur_owner;
  logic            cur_held;

  assign op        = lsu_op_e'(op_i);
  assign cur_owner = owner_i[int'(idx_i)*ID_W +: ID_W];
  assign cur_held  = held_i[idx_i];

  always_comb begin
    held_o  = held_i;
    owner_o = owner_i;
    count_o = count_i;
    grant_o = 1'b0;
    prior_o = 1'b0;
    err_o   = 1'b0;
    if (valid_i) begin
      unique case (op)
        OP_MTX_TAKE: begin
          prior_o = cur_held;
          if (!cur_held) begin
            held_o[idx_i]                          = 1'b1;
            owner_o[int'(idx_i)*ID_W +: ID_W]      = MY_ID;
            grant_o                                = 1'b1;
          end else if (cur_owner == MY_ID) begin
            err_o = 1'b1;  // relock by holder
          end
        end
        OP_MTX_GIVE: begin
          if (cur_held && cur_owner == MY_ID) begin
            held_o[idx_i] = 1'b0;
            grant_o       = 1'b1;
          end else begin
            err_o = 1'b1;  // not the holder, or already free
          end
        end
        OP_SEM_TAKE: begin
          if (count_i < limit_i) begin
            count_o = count_i + CNT_W'(1);
            grant_o = 1'b1;
          end
        end
        OP_SEM_GIVE: begin
          if (count_i != '0) begin
            count_o = count_i - CNT_W'(1);
            grant_o = 1'b1;
          end else begin
            err_o = 1'b1;  // underflow
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_state.sv
module lsu_state #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_MTX   = 8,
  parameter int CNT_W     = 5,
  parameter int LIMIT_RST = 10,
  localparam int ID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_MTX-1:0]      held_d,
  input  logic [NUM_MTX*ID_W-1:0] owner_d,
  input  logic [CNT_W-1:0]        count_d,
  input  logic                    cfg_we_i,
  input  logic [CNT_W-1:0]        cfg_limit_i,
  output logic [NUM_MTX-1:0]      held_q,
  output logic [NUM_MTX*ID_W-1:0] owner_q,
  output logic [CNT_W-1:0]        count_q,
  output logic [CNT_W-1:0]        limit_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= '0;
      owner_q <= '0;
      count_q <= '0;
    end else begin
      held_q  <= held_d;
      owner_q <= owner_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       limit_q <= CNT_W'(LIMIT_RST);
    else if (cfg_we_i) limit_q <= cfg_limit_i;
  end
endmodule

// File: rtl/lsu_rsp.sv
module lsu_rsp #(
  parameter int NUM_REQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] valid_d,
  input  logic [NUM_REQ-1:0] grant_d,
  input  logic [NUM_REQ-1:0] prior_d,
  input  logic [NUM_REQ-1:0] err_d,
  output logic [NUM_REQ-1:0] valid_q,
  output logic [NUM_REQ-1:0] grant_q,
  output logic [NUM_REQ-1:0] prior_q,
  output logic [NUM_REQ-1:0] err_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      grant_q <= '0;
      prior_q <= '0;
      err_q   <= '0;
    end else begin
      valid_q <= valid_d;
      grant_q <= grant_d;
      prior_q <= prior_d;
      err_q   <= err_d;
    end
  end
endmodule

// File: rtl/lock_sem_unit.sv
module lock_sem_unit #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_MTX   = 8,
  parameter int CNT_W     = 5,
  parameter int LIMIT_RST = 10,
  localparam int ID_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int IDX_W = (NUM_MTX > 1) ? $clog2(NUM_MTX) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_REQ-1:0]       req_valid_i,
  input  logic [2*NUM_REQ-1:0]     req_op_i,
  input  logic [IDX_W*NUM_REQ-1:0] req_idx_i,
  input  logic                     cfg_we_i,
  input  logic [CNT_W-1:0]         cfg_limit_i,
  output logic [NUM_REQ-1:0]       rsp_valid_o,
  output logic [NUM_REQ-1:0]       rsp_grant_o,
  output logic [NUM_REQ-1:0]       rsp_prior_o,
  output logic [NUM_REQ-1:0]       rsp_err_o,
  output logic [NUM_MTX-1:0]       mtx_held_o,
  output logic [CNT_W-1:0]         sem_count_o,
  output logic [CNT_W-1:0]         sem_limit_o
);
  logic [NUM_MTX-1:0]      held_c  [NUM_REQ+1];
  logic [NUM_MTX*ID_W-1:0] owner_c [NUM_REQ+1];
  logic [CNT_W-1:0]        count_c [NUM_REQ+1];

  logic [NUM_MTX-1:0]      held_q;
  logic [NUM_MTX*ID_W-1:0] owner_q;
  logic [CNT_W-1:0]        count_q;
  logic [CNT_W-1:0]        limit_q;

  logic [NUM_REQ-1:0] grant_c, prior_c, err_c;

  assign held_c[0]  = held_q;
  assign owner_c[0] = owner_q;
  assign count_c[0] = count_q;

  // Ascending lane order: each stage sees the state left by the lanes below.
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_lane
    lsu_stage #(
      .NUM_REQ(NUM_REQ),
      .NUM_MTX(NUM_MTX),
      .CNT_W  (CNT_W),
      .REQ_ID (g)
    ) u_stage (
      .valid_i(req_valid_i[g]),
      .op_i   (req_op_i[2*g +: 2]),
      .idx_i  (req_idx_i[IDX_W*g +: IDX_W]),
      .held_i (held_c[g]),
      .owner_i(owner_c[g]),
      .count_i(count_c[g]),
      .limit_i(limit_q),
      .held_o (held_c[g+1]),
      .owner_o(owner_c[g+1]),
      .count_o(count_c[g+1]),
      .grant_o(grant_c[g]),
      .prior_o(prior_c[g]),
      .err_o  (err_c[g])
    );
  end

  lsu_state #(
    .NUM_REQ  (NUM_REQ),
    .NUM_MTX  (NUM_MTX),
    .CNT_W    (CNT_W),
    .LIMIT_RST(LIMIT_RST)
  ) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .held_d     (held_c[NUM_REQ]),
    .owner_d    (owner_c[NUM_REQ]),
    .count_d    (count_c[NUM_REQ]),
    .cfg_we_i   (cfg_we_i),
    .cfg_limit_i(cfg_limit_i),
    .held_q     (held_q),
    .owner_q    (owner_q),
    .count_q    (count_q),
    .limit_q    (limit_q)
  );

  lsu_rsp #(
    .NUM_REQ(NUM_REQ)
  ) u_rsp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_d(req_valid_i),
    .grant_d(grant_c),
    .prior_d(prior_c),
    .err_d  (err_c),
    .valid_q(rsp_valid_o),
    .grant_q(rsp_grant_o),
    .prior_q(rsp_prior_o),
    .err_q  (rsp_err_o)
  );

  assign mtx_held_o  = held_q;
  assign sem_count_o = count_q;
  assign sem_limit_o = limit_q;
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
  parameter int NUM_REQ = 4,
  parameter int NUM_MTX = 8,
  parameter int CNT_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_REQ-1:0] req_valid_i,
  input logic               cfg_we_i,
  input logic [CNT_W-1:0]   cfg_limit_i,
  input logic [NUM_REQ-1:0] rsp_valid_o,
  input logic [NUM_REQ-1:0] rsp_grant_o,
  input logic [NUM_REQ-1:0] rsp_err_o,
  input logic [NUM_MTX-1:0] mtx_held_o,
  input logic [CNT_W-1:0]   sem_count_o,
  input logic [CNT_W-1:0]   sem_limit_o
);
  p_rsp_timing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> rsp_valid_o == $past(req_valid_i));

  p_rsp_qualified_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rsp_grant_o | rsp_err_o) & ~rsp_valid_o) == '0);

  p_grant_err_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_grant_o & rsp_err_o) == '0);

  p_lock_set_granted_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ((mtx_held_o & ~$past(mtx_held_o)) != '0)) |-> (rsp_grant_o != '0));

  p_lock_clear_granted_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ((~mtx_held_o & $past(mtx_held_o)) != '0)) |-> (rsp_grant_o != '0));

  p_count_within_limit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && sem_count_o > $past(sem_count_o)) |-> sem_count_o <= $past(sem_limit_o));

  p_count_drop_granted_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && sem_count_o < $past(sem_count_o)) |-> (rsp_grant_o != '0));

  p_limit_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(cfg_we_i)) |-> sem_limit_o == $past(cfg_limit_i));

  p_limit_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(cfg_we_i)) |-> $stable(sem_limit_o));
endmodule

bind lock_sem_unit lsu_checker #(
  .NUM_REQ(NUM_REQ),
  .NUM_MTX(NUM_MTX),
  .CNT_W  (CNT_W)
) u_lsu_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_limit_i(cfg_limit_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_grant_o(rsp_grant_o),
  .rsp_err_o  (rsp_err_o),
  .mtx_held_o (mtx_held_o),
  .sem_count_o(sem_count_o),
  .sem_limit_o(sem_limit_o)
);

// File: tb/lock_sem_unit_test.sv
module lock_sem_unit_test;
  localparam int NR = 4;
  localparam int NM = 8;
  localparam int CW = 5;
  localparam int IW = 3;

  localparam logic [1:0] MT = 2'b00, MG = 2'b01, ST = 2'b10, SG = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] req_valid = '0;
  logic [2*NR-1:0] req_op = '0;
  logic [IW*NR-1:0] req_idx = '0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_limit = '0;
  logic [NR-1:0] rsp_valid, rsp_grant, rsp_prior, rsp_err;
  logic [NM-1:0] held;
  logic [CW-1:0] count, limit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lock_sem_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_idx_i(req_idx),
    .cfg_we_i(cfg_we), .cfg_limit_i(cfg_limit),
    .rsp_valid_o(rsp_valid), .rsp_grant_o(rsp_grant),
    .rsp_prior_o(rsp_prior), .rsp_err_o(rsp_err),
    .mtx_held_o(held), .sem_count_o(count), .sem_limit_o(limit)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int id, input logic [1:0] op, input int idx);
    req_valid[id] = 1'b1;
    req_op[2*id +: 2] = op;
    req_idx[IW*id +: IW] = IW'(idx);
  endtask

  // Requests were driven on a falling edge; results are due one edge later.
  task automatic step();
    @(negedge clk);
    req_valid = '0;
    req_op = '0;
    req_idx = '0;
    cfg_we = 1'b0;
  endtask

  task automatic rsp_chk(input string tag, input int v, input int g, input int p, input int e);
    check({tag, " valid"}, rsp_valid, v);
    check({tag, " grant"}, rsp_grant, g);
    check({tag, " prior"}, rsp_prior, p);
    check({tag, " err"}, rsp_err, e);
  endtask

  task automatic t_reset();
    check("R1 held", held, 0);
    check("R1 count", count, 0);
    check("R1 limit", limit, 10);
    check("R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_mutex();
    put(0, MT, 3); step();
    rsp_chk("R2 take free", 4'b0001, 4'b0001, 4'b0000, 4'b0000);
    check("R2 held set", held, 8'h08);
    step();
    check("R2 rsp one cycle only", rsp_valid, 0);
    put(1, MT, 3); step();
    rsp_chk("R3 take held", 4'b0010, 4'b0000, 4'b0010, 4'b0000);
    check("R3 held unchanged", held, 8'h08);
    put(0, MT, 3); step();
    rsp_chk("R4 relock", 4'b0001, 4'b0000, 4'b0001, 4'b0001);
    check("R4 held unchanged", held, 8'h08);
    put(2, MG, 3); step();
    rsp_chk("R5 foreign release", 4'b0100, 4'b0000, 4'b0000, 4'b0100);
    check("R5 held kept", held, 8'h08);
    put(0, MG, 3); step();
    rsp_chk("R5 owner release", 4'b0001, 4'b0001, 4'b0000, 4'b0000);
    check("R5 held cleared", held, 8'h00);
    put(1, MG, 3); step();
    rsp_chk("R5 release free", 4'b0010, 4'b0000, 4'b0000, 4'b0010);
    check("R5 still free", held, 8'h00);
  endtask

  task automatic t_same_cycle();
    put(0, MT, 1); put(1, MT, 5); put(2, MT, 5); put(3, MT, 5); step();
    rsp_chk("R6 contend", 4'b1111, 4'b0011, 4'b1100, 4'b0000);
    check("R6 held", held, 8'h22);
    put(1, MG, 5); put(2, MT, 5); step();
    rsp_chk("R6 handover", 4'b0110, 4'b0110, 4'b0000, 4'b0000);
    check("R6 held after handover", held, 8'h22);
    put(1, MG, 5); step();
    check("R6 old owner rejected", rsp_err, 4'b0010);
    put(0, MG, 1); put(2, MG, 5); step();
    check("R6 cleanup grant", rsp_grant, 4'b0101);
    check("R6 cleanup held", held, 0);
  endtask

  task automatic t_sem();
    for (int k = 1; k <= 10; k++) begin
      put(0, ST, 0); step();
      check("R7 take grant", rsp_grant, 1);
      check("R7 count", count, k);
    end
    put(0, ST, 0); step();
    rsp_chk("R7 at limit", 1, 0, 0, 0);
    check("R7 count held", count, 10);
    put(3, SG, 0); step();
    put(3, SG, 0); step();
    check("R8 give", count, 8);
    for (int i = 0; i < NR; i++) put(i, ST, 0);
    step();
    rsp_chk("R6 R7 multi take", 4'b1111, 4'b0011, 0, 0);
    check("R7 count full", count, 10);
    for (int k = 9; k >= 0; k--) begin
      put(2, SG, 0); step();
      check("R8 give grant", rsp_grant, 4'b0100);
      check("R8 count", count, k);
    end
    put(2, SG, 0); step();
    rsp_chk("R8 underflow", 4'b0100, 0, 0, 4'b0100);
    check("R8 count floor", count, 0);
    put(1, ST, 7); step();
    check("R10 count", count, 1);
    check("R10 held untouched", held, 0);
    put(1, SG, 6); step();
    check("R10 held untouched give", held, 0);
    check("R10 count back", count, 0);
  endtask

  task automatic t_limit();
    cfg_we = 1'b1; cfg_limit = 5'd1; put(0, ST, 0); put(1, ST, 0); step();
    check("R9 old limit used", rsp_grant, 4'b0011);
    check("R9 count", count, 2);
    check("R9 limit", limit, 1);
    put(0, ST, 0); step();
    check("R7 over lowered limit", rsp_grant, 0);
    check("R7 count kept", count, 2);
    cfg_we = 1'b1; cfg_limit = 5'd3; step();
    check("R9 limit 3", limit, 3);
    put(0, ST, 0); put(1, ST, 0); step();
    check("R7 one slot", rsp_grant, 4'b0001);
    check("R7 count 3", count, 3);
    put(0, SG, 0); put(1, SG, 0); put(2, SG, 0); put(3, SG, 0); step();
    rsp_chk("R8 drain", 4'b1111, 4'b0111, 0, 4'b1000);
    check("R8 drained", count, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mutex();
    t_same_cycle();
    t_sem();
    t_limit();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule